// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block gathers the five interrupt conditions of a serial controller into one interrupt request line and one read-only identification byte. Each condition is masked by its enable bit and then captured in a sticky pending flag. A fixed priority encoder picks the most urgent pending flag and reports it as a 3-bit cause code. Bit 0 of the byte is an active-low "interrupt pending" flag.

Software services the line by reading the identification byte. The read strobe clears only the cause reported in that cycle, so lower-priority causes stay pending and appear on later reads. A condition that is still asserted, or that arrives during the read, is captured again at the same clock edge and is not lost. The upper two bits of the byte show whether the controller's FIFOs are enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable mapping: `ier[3]` gates the modem-change source, `ier[2]` gates line-error, `ier[1]` gates transmit-empty, and `ier[0]` gates both receive-ready and receive-timeout. A condition is captured only while its enable is 1. A pending flag is dropped one clock after its enable goes to 0 and does not return when the enable is set again.
- R2: Priority from highest to lowest is receive-timeout, line-error, receive-ready, transmit-empty, modem-change. The byte reports the highest pending source.
- R3: Cause code in `id_reg[3:1]`: modem-change 000, transmit-empty 001, receive-ready 010, line-error 011, receive-timeout 110. No other value appears.
- R4: `id_reg[0]` is 0 and `irq` is 1 while any source is pending. With nothing pending, `id_reg[0]` is 1, the cause code is 000 and `irq` is 0. The idle byte is 0x01, or 0xC1 with FIFOs on.
- R5: A cycle with `id_rd` high clears, at the next clock, the pending flag of the cause reported in that cycle. Other pending flags are kept and are reported on later reads, in priority order.
- R6: A condition that is still asserted during the read of its own cause remains pending. A condition that arrives in the same cycle as a read of any cause is captured.
- R7: `id_reg[7]` and `id_reg[6]` both equal `fifo_on`. `id_reg[5:4]` are always 0.
- R8: An enabled condition that lasts one cycle is held pending from the next clock until it is cleared by a read. Reset clears all pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Interrupt enable bits |
| fifo_on | input | 1 | FIFOs enabled indication |
| ev_line_err | input | 1 | Receiver line error condition |
| ev_rx_ready | input | 1 | Received data available condition |
| ev_rx_timeout | input | 1 | Character timeout condition |
| ev_tx_empty | input | 1 | Transmit holding register empty condition |
| ev_modem | input | 1 | Modem status change condition |
| id_rd | input | 1 | Read strobe of the identification byte |
| id_reg | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check the following on every cycle:
- The cause code only takes legal values.
- The idle byte and `irq` agree with each other.
- The FIFO and reserved bits are correct.
- An enabled timeout always wins on the next cycle.
- An enabled condition always raises `irq`.
- Clearing all enables empties the register.
- A read of a cause that is no longer asserted removes that cause.

The bench scenarios cover what a property cannot express. It sweeps every mix of pending sources against every enable pattern and both FIFO settings, then drains each mix read by read and checks the full descending report order. It also checks that a disabled source does not come back when re-enabled, and that a condition held high or arriving during a read survives that read.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       fifo_on,
  input  logic       ev_line_err,
  input  logic       ev_rx_ready,
  input  logic       ev_rx_timeout,
  input  logic       ev_tx_empty,
  input  logic       ev_modem,
  input  logic       id_rd,
  output logic [7:0] id_reg,
  output logic       irq
);
  localparam int NSRC = 5;
  localparam int S_MS = 0, S_TX = 1, S_RX = 2, S_LE = 3, S_TO = 4;

  logic [NSRC-1:0] ev, en, pend, pend_d, top_oh;
  logic [2:0]      code;

  // source vector ordered by rising priority
  assign ev = {ev_rx_timeout, ev_line_err, ev_rx_ready, ev_tx_empty, ev_modem};
  assign en = {ier[0], ier[2], ier[0], ier[1], ier[3]};

  always_comb begin
    top_oh = '0;
    code   = 3'b000;
    if (pend[S_TO]) begin
      top_oh[S_TO] = 1'b1; code = 3'b110;
    end else if (pend[S_LE]) begin
      top_oh[S_LE] = 1'b1; code = 3'b011;
    end else if (pend[S_RX]) begin
      top_oh[S_RX] = 1'b1; code = 3'b010;
    end else if (pend[S_TX]) begin
      top_oh[S_TX] = 1'b1; code = 3'b001;
    end else if (pend[S_MS]) begin
      top_oh[S_MS] = 1'b1; code = 3'b000;
    end
  end

  // clear only the reported cause; live or new conditions re-capture
  assign pend_d = en & (ev | (pend & ~(id_rd ? top_oh : '0)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;

  assign irq    = |pend;
  assign id_reg = {fifo_on, fifo_on, 2'b00, code, ~irq};
endmodule

module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier,
  input logic       fifo_on,
  input logic       ev_line_err,
  input logic       ev_rx_ready,
  input logic       ev_rx_timeout,
  input logic       ev_tx_empty,
  input logic       ev_modem,
  input logic       id_rd,
  input logic [7:0] id_reg,
  input logic       irq
);
  logic [2:0] cause;
  logic       cause_live;
  logic       any_en_ev;

  assign cause = id_reg[3:1];
  assign any_en_ev = (ev_modem & ier[3]) | (ev_tx_empty & ier[1]) |
                     (ev_rx_ready & ier[0]) | (ev_line_err & ier[2]) |
                     (ev_rx_timeout & ier[0]);

  always_comb
    case (cause)
      3'b110:  cause_live = ev_rx_timeout;
      3'b011:  cause_live = ev_line_err;
      3'b010:  cause_live = ev_rx_ready;
      3'b001:  cause_live = ev_tx_empty;
      default: cause_live = ev_modem;
    endcase

  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !id_reg[0] |-> (cause inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110}));

  a_r4_idle_byte: assert property (@(posedge clk) disable iff (!rst_n)
    id_reg[0] |-> (cause == 3'b000 && !irq));

  a_r4_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !id_reg[0]);

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    id_reg[5:4] == 2'b00 && id_reg[7:6] == {2{fifo_on}});

  a_r2_timeout_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_timeout && ier[0]) |=> (cause == 3'b110 && !id_reg[0]));

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    any_en_ev |=> irq);

  a_r1_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'h0) |=> id_reg[0]);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && !id_reg[0] && !cause_live) |=> (id_reg[0] || cause != $past(cause)));

  a_r6_live_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && ev_line_err && ier[2]) |=> (!id_reg[0] && cause >= 3'b011));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic fifo_on = 1'b0, id_rd = 1'b0;
  logic ev_line_err = 1'b0, ev_rx_ready = 1'b0, ev_rx_timeout = 1'b0;
  logic ev_tx_empty = 1'b0, ev_modem = 1'b0;
  logic [7:0] id_reg;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident dut (.*);

  // bit order of masks: [4] timeout, [3] line error, [2] rx ready, [1] tx empty, [0] modem
  function automatic logic [4:0] en_of(logic [3:0] m);
    return {m[0], m[2], m[0], m[1], m[3]};
  endfunction

  function automatic int top_idx(logic [4:0] r);
    for (int i = 4; i >= 0; i--) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_byte(logic [4:0] r, logic f);
    int t = top_idx(r);
    logic [2:0] c = (t == 4) ? 3'd6 : (t < 0 ? 3'd0 : 3'(t));
    return {f, f, 2'b00, c, (t < 0)};
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic set_ev(logic [4:0] p);
    {ev_rx_timeout, ev_line_err, ev_rx_ready, ev_tx_empty, ev_modem} = p;
  endtask

  task automatic chk(string req, logic [7:0] exp);
    n_chk++;
    if (id_reg !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: id_reg=%02h irq=%0b expected id_reg=%02h irq=%0b",
               req, id_reg, irq, exp, ~exp[0]);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    tick; tick;
    rst_n = 1'b1;
    tick;
    chk("R4 R8 reset idle", 8'h01);

    // exhaustive: fifo setting x enable pattern x pending mix, then drain
    for (int f = 0; f < 2; f++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 32; p++) begin
          logic [4:0] rem;
          fifo_on = f[0]; ier = m[3:0]; id_rd = 1'b0;
          set_ev(p[4:0]);
          tick;
          set_ev(5'b0);
          rem = p[4:0] & en_of(m[3:0]);
          chk("R1 R3 R7 R8 capture", exp_byte(rem, f[0]));
          while (rem != 0) begin
            id_rd = 1'b1;
            tick;
            rem[top_idx(rem)] = 1'b0;
            chk("R2 R4 R5 drain order", exp_byte(rem, f[0]));
          end
          id_rd = 1'b0;
        end

    fifo_on = 1'b0;
    // R1: disable drops the flag, re-enable does not restore it
    ier = 4'h2; ev_tx_empty = 1'b1; tick; ev_tx_empty = 1'b0;
    chk("R1 tx empty pending", 8'h02);
    ier = 4'h0; tick;
    chk("R1 dropped on disable", 8'h01);
    ier = 4'h2; tick;
    chk("R1 not restored", 8'h01);

    // R6: condition still asserted across a read of its own cause
    ier = 4'hF; ev_line_err = 1'b1; tick;
    chk("R6 line error pending", 8'h06);
    id_rd = 1'b1; tick;
    chk("R6 live cause kept", 8'h06);
    ev_line_err = 1'b0; tick;
    id_rd = 1'b0;
    chk("R6 cleared once released", 8'h01);

    // R6: new higher cause arriving during a read of a lower cause
    ev_tx_empty = 1'b1; tick; ev_tx_empty = 1'b0;
    chk("R6 tx empty reported", 8'h02);
    id_rd = 1'b1; ev_line_err = 1'b1; tick;
    id_rd = 1'b0; ev_line_err = 1'b0;
    chk("R6 same-cycle arrival kept", 8'h06);
    id_rd = 1'b1; tick; id_rd = 1'b0;
    chk("R5 final clear", 8'h01);

    // R7: FIFO indication with idle and pending
    fifo_on = 1'b1; tick;
    chk("R7 idle with fifo", 8'hC1);
    ev_rx_timeout = 1'b1; ev_modem = 1'b1; tick; ev_rx_timeout = 1'b0; ev_modem = 1'b0;
    chk("R2 R7 timeout over modem", 8'hCC);
    id_rd = 1'b1; tick;
    chk("R5 modem next", 8'hC0);
    tick; id_rd = 1'b0;
    chk("R5 empty", 8'hC1);

    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary;
      $finish;
    end
  end
endmodule